// File: doc/BRIEF.md
# Single-Level Interrupt Sequencer

This block decides when a processor core should divert into its external interrupt handler. It also tracks how interrupt and synchronous-exception handlers nest. It watches one interrupt request line, the global interrupt enable, an exception indication and a return-from-trap strobe. It keeps two busy flags, one for an interrupt handler in progress and one for an exception handler in progress.

A request is accepted only when the core is idle. While either handler runs, further requests wait. A return strobe closes the exception handler first when one is open, and closes the interrupt handler otherwise. An exception may therefore open inside an interrupt handler, and two returns unwind the pair in order. The cause value handed to the core is a fixed constant, because there is a single source.

Top module: `irq_sequencer`

## Requirements
- R1: `takeIrq` is high in a cycle exactly when `irqReq` and `irqEnable` are both high, `excFlag` is low, and neither handler is busy. With `irqEnable` low, a request is not taken.
- R2: `irqCause` always equals 32'h1000_0010.
- R3: After `takeIrq`, the interrupt handler is busy. `takeIrq` stays low on later requests until the interrupt handler is closed by a return.
- R4: While the exception handler is busy, interrupt requests are not taken.
- R5: A `trapRet` pulse while the exception handler is busy leaves `irqReturn` low and closes the exception handler.
- R6: A `trapRet` pulse while only the interrupt handler is busy raises `irqReturn` combinationally in that same cycle and closes the interrupt handler.
- R7: An exception raised during an interrupt handler is accepted. The first `trapRet` afterwards closes the exception without `irqReturn`. The second `trapRet` raises `irqReturn` and closes the interrupt.
- R8: In the cycle right after the return that raised `irqReturn`, a request with the enable high is taken.
- R9: A synchronous active-high `rst` clears both busy flags.
- R10: When `excFlag` and a request arrive in the same cycle on an idle sequencer, the exception wins. `takeIrq` stays low and the exception handler becomes busy.
- R11: A `trapRet` pulse with no handler busy leaves `irqReturn` low and changes no state, so a following request is still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqReq | input | 1 | External interrupt request |
| irqEnable | input | 1 | Global interrupt enable |
| excFlag | input | 1 | Synchronous exception raised this cycle |
| trapRet | input | 1 | Return-from-trap strobe |
| takeIrq | output | 1 | Take the interrupt this cycle |
| irqCause | output | 32 | Fixed interrupt cause code |
| irqReturn | output | 1 | The current return closes the interrupt handler |

## Verification
Some rules hold on every cycle and are checked by the assertions. These are: the take conditions, the constant cause, exception priority and blocking by busy handlers, that a take sets the interrupt flag, and that a return clears the right flag. The bench's scenarios show the behaviour that depends on a sequence of events. That covers the full nested unwind of exception-inside-interrupt, and a new request accepted on the cycle right after a return. It also covers a stray return with nothing open, and reset in the middle of a handler.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  // Strobes from control to the flag datapath
  typedef struct packed {
    logic take;     // accept the interrupt now
    logic closeExc; // return closes exception handler
    logic closeIrq; // return closes interrupt handler
  } seqStrobes_t;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic        irqReq,
  input  logic        irqEnable,
  input  logic        excFlag,
  input  logic        trapRet,
  input  logic        irqBusy,
  input  logic        excBusy,
  output seqStrobes_t strobes
);
  logic idle;

  always_comb begin
    idle             = !irqBusy && !excBusy;
    // exception in the same cycle beats the request
    strobes.take     = irqReq && irqEnable && !excFlag && idle;
    // a return is steered to the innermost open handler
    strobes.closeExc = trapRet && excBusy;
    strobes.closeIrq = trapRet && !excBusy && irqBusy;
  end
endmodule

// File: rtl/irq_seq_flags.sv
module irq_seq_flags
  import irq_seq_pkg::*;
#(
  parameter int unsigned           CAUSE_W   = 32,
  parameter logic [CAUSE_W-1:0]    CAUSE_VAL = 32'h1000_0010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               excFlag,
  input  seqStrobes_t        strobes,
  output logic               irqBusy,
  output logic               excBusy,
  output logic [CAUSE_W-1:0] cause
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irqBusy <= 1'b0;
      excBusy <= 1'b0;
    end else begin
      irqBusy <= strobes.take || (irqBusy && !strobes.closeIrq);
      excBusy <= excFlag || (excBusy && !strobes.closeExc);
    end
  end

  assign cause = CAUSE_VAL;
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_seq_pkg::*;
#(
  parameter int unsigned        CAUSE_W   = 32,
  parameter logic [CAUSE_W-1:0] CAUSE_VAL = 32'h1000_0010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irqReq,
  input  logic               irqEnable,
  input  logic               excFlag,
  input  logic               trapRet,
  output logic               takeIrq,
  output logic [CAUSE_W-1:0] irqCause,
  output logic               irqReturn
);
  seqStrobes_t strobes;
  logic        irqBusy;
  logic        excBusy;

  irq_seq_ctrl u_ctrl (
    .irqReq   (irqReq),
    .irqEnable(irqEnable),
    .excFlag  (excFlag),
    .trapRet  (trapRet),
    .irqBusy  (irqBusy),
    .excBusy  (excBusy),
    .strobes  (strobes)
  );

  irq_seq_flags #(.CAUSE_W(CAUSE_W), .CAUSE_VAL(CAUSE_VAL)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .excFlag(excFlag),
    .strobes(strobes),
    .irqBusy(irqBusy),
    .excBusy(excBusy),
    .cause  (irqCause)
  );

  assign takeIrq   = strobes.take;
  assign irqReturn = strobes.closeIrq;
endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
  parameter int unsigned        CAUSE_W   = 32,
  parameter logic [CAUSE_W-1:0] CAUSE_VAL = 32'h1000_0010
) (
  input logic               clk,
  input logic               rst,
  input logic               irqReq,
  input logic               irqEnable,
  input logic               excFlag,
  input logic               trapRet,
  input logic               takeIrq,
  input logic [CAUSE_W-1:0] irqCause,
  input logic               irqReturn,
  input logic               irqBusy,
  input logic               excBusy
);
  a_r1_take_needs_req_en: assert property (@(posedge clk) disable iff (rst)
    takeIrq |-> (irqReq && irqEnable));

  a_r2_cause_const: assert property (@(posedge clk) disable iff (rst)
    irqCause == CAUSE_VAL);

  a_r3_take_sets_busy: assert property (@(posedge clk) disable iff (rst)
    takeIrq |=> (irqBusy && !takeIrq));

  a_r3_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    irqBusy |-> !takeIrq);

  a_r4_exc_blocks: assert property (@(posedge clk) disable iff (rst)
    excBusy |-> !takeIrq);

  a_r5_exc_return_quiet: assert property (@(posedge clk) disable iff (rst)
    (trapRet && excBusy && !excFlag) |-> (!irqReturn ##1 !excBusy));

  a_r6_return_closes_irq: assert property (@(posedge clk) disable iff (rst)
    irqReturn |-> (trapRet && irqBusy) ##1 !irqBusy);

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!irqBusy && !excBusy));

  a_r10_exc_priority: assert property (@(posedge clk) disable iff (rst)
    excFlag |-> !takeIrq ##1 excBusy);

  a_r11_stray_return: assert property (@(posedge clk) disable iff (rst)
    (!irqBusy && !excBusy) |-> !irqReturn);
endmodule

bind irq_sequencer irq_sequencer_chk #(.CAUSE_W(CAUSE_W), .CAUSE_VAL(CAUSE_VAL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irqReq   (irqReq),
  .irqEnable(irqEnable),
  .excFlag  (excFlag),
  .trapRet  (trapRet),
  .takeIrq  (takeIrq),
  .irqCause (irqCause),
  .irqReturn(irqReturn),
  .irqBusy  (irqBusy),
  .excBusy  (excBusy)
);

// File: tb/sim_irq_sequencer.sv
`timescale 1ns/100ps
module sim_irq_sequencer;
  localparam logic [31:0] EXP_CAUSE = 32'h1000_0010;
  localparam int NVEC = 15;
  // {irqReq, irqEnable, excFlag, trapRet, expTake, expReturn}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b0000_00, // 0 idle
    6'b1000_00, // 1 R1 enable low
    6'b1100_10, // 2 R1 take
    6'b1100_00, // 3 R3 blocked while busy
    6'b0001_01, // 4 R6 return closes irq
    6'b1100_10, // 5 R8 taken right after return
    6'b1110_00, // 6 R7 exception inside irq
    6'b0001_00, // 7 R7 first return closes exception
    6'b1100_00, // 8 R7 irq still busy
    6'b0001_01, // 9 R7 second return closes irq
    6'b1110_00, // 10 R10 exception beats request
    6'b1100_00, // 11 R4 blocked by exception
    6'b0001_00, // 12 R5 return closes exception
    6'b0001_00, // 13 R11 stray return
    6'b1100_10  // 14 R11 no effect, request taken
  };

  logic clk = 1'b0;
  logic rst, irqReq, irqEnable, excFlag, trapRet;
  logic takeIrq, irqReturn;
  logic [31:0] irqCause;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_sequencer u0 (
    .clk(clk), .rst(rst), .irqReq(irqReq), .irqEnable(irqEnable),
    .excFlag(excFlag), .trapRet(trapRet), .takeIrq(takeIrq),
    .irqCause(irqCause), .irqReturn(irqReturn)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic rq, logic en, logic ex, logic rt);
    @(negedge clk);
    irqReq = rq; irqEnable = en; excFlag = ex; trapRet = rt;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    irqReq = 0; irqEnable = 0; excFlag = 0; trapRet = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; irqReq = 0; irqEnable = 0; excFlag = 0; trapRet = 0;
    doReset();
    // reset state: idle outputs
    drive(0, 0, 0, 0);
    check("R9 reset take", {31'd0, takeIrq}, 32'd0);
    check("R9 reset return", {31'd0, irqReturn}, 32'd0);
    check("R2 cause", irqCause, EXP_CAUSE);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      check($sformatf("vec%0d take", i), {31'd0, takeIrq}, {31'd0, VEC[i][1]});
      check($sformatf("vec%0d return", i), {31'd0, irqReturn}, {31'd0, VEC[i][0]});
      check("R2 cause", irqCause, EXP_CAUSE);
    end

    // R9: reset in the middle of an interrupt handler
    doReset();
    drive(1, 1, 0, 0);
    check("R9 take before reset", {31'd0, takeIrq}, 32'd1);
    doReset();
    drive(1, 1, 0, 0);
    check("R9 irq flag cleared", {31'd0, takeIrq}, 32'd1);

    // R9: reset clears the exception flag too
    doReset();
    drive(0, 0, 1, 0);
    doReset();
    drive(1, 1, 0, 0);
    check("R9 exc flag cleared", {31'd0, takeIrq}, 32'd1);

    // R5: return in the same cycle as a new exception keeps exception open
    doReset();
    drive(0, 0, 1, 0);
    drive(0, 0, 1, 1);
    check("R5 return quiet", {31'd0, irqReturn}, 32'd0);
    drive(1, 1, 0, 0);
    check("R4 still blocked", {31'd0, takeIrq}, 32'd0);
    drive(0, 0, 0, 1);
    drive(1, 1, 0, 0);
    check("R5 closed then taken", {31'd0, takeIrq}, 32'd1);

    drive(0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule